// File: doc/BRIEF.md
# Configuration address translator

This block is the front end of a host bridge. It sits on a simple memory-mapped host bus and offers two 4 KiB windows. The first window holds a single 32-bit index register. The second window is a data port. Each access to the data port turns into one configuration read or write request on a downstream port. The block builds the request address from the latched index and the low bits of the data-port offset. It recognises three index layouts: a direct pass-through form, a type-1 style form, and a legacy form in which a single set bit picks the slot.

Host requests and responses, downstream requests and downstream completions all use valid/ready-style handshakes. The block handles one transaction at a time:

- `host_req_ready` is high only while the block is idle.
- A downstream request holds its valid and payload until `cfg_req_ready` is seen.
- A host response holds its valid and data until `host_rsp_ready` is seen.
- A downstream completion is taken in the first cycle in which `cfg_rsp_valid` is high while the block waits for one.

The block also folds the four interrupt pins of each attached device slot onto four shared, registered interrupt lines. These lines are meant to feed interrupt-controller inputs 27 to 30.

Top module: `cfg_addr_xlate`

## Requirements
- R1: Host address bit 12 chooses the window: 0 is the index window, 1 is the data window. An index-window write stores all 32 bits of `host_req_wdata`, whatever the size and offset. An index-window read returns the stored value. Neither access issues a downstream request. Reset clears the index to zero.
- R2: If index bit 31 is set, a data-window access requests address {index[31:2], offset[1:0]}.
- R3: If index bit 31 is clear and index bit 0 is set, the requested address is {index[31:3], offset[2:0]}.
- R4: If index bits 31 and 0 are both clear, the address is formed by ORing four fields:
  - the slot number shifted left by 11, where the slot number is the bit number (11 to 31) of the lowest set index bit at or above bit 11;
  - index[10:8] placed at bits 10:8;
  - index[7:3] placed at bits 7:3;
  - offset[2:0].
- R5: In the R4 form, if index bits 31:11 are all zero, the slot number is all ones. This sets every address bit from 11 upward.
- R6: `cfg_req_be` depends on the size code and the offset:
  - size 0 (byte): a single enable at bit offset[1:0];
  - size 1 (half): 4'b0011 when offset bit 1 is 0, 4'b1100 when it is 1;
  - sizes 2 and 3: 4'b1111.
- R7: A data-window access raises `cfg_req_valid` in the cycle after acceptance. The address, byte enables, write flag and write data stay stable until `cfg_req_ready`. The host response follows the next `cfg_rsp_valid`, and carries `cfg_rsp_rdata` for reads and zero for writes.
- R8: `host_req_ready` is low while a transaction is in flight. `host_rsp_valid` and `host_rsp_rdata` hold until `host_rsp_ready`.
- R9: Pin p of slot s (bit s*4+p of `dev_intx`) drives `irq_out[(p + SLOT_BASE + s) mod 4]`. Each output is the OR of its routed pins, registered once.
- R10: While and right after reset, `irq_out` is zero, no request or response is valid, and `host_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Host request accepted (idle) |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | OFF_W+1 | Bit OFF_W picks the window, low bits are the offset |
| host_req_size | input | 2 | 0 byte, 1 half, 2 or 3 word |
| host_req_wdata | input | 32 | Host write data, lane aligned |
| host_rsp_valid | output | 1 | Host response valid |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_rdata | output | 32 | Read data (zero for writes) |
| cfg_req_valid | output | 1 | Downstream request valid |
| cfg_req_ready | input | 1 | Downstream takes the request |
| cfg_req_write | output | 1 | Downstream request is a write |
| cfg_req_addr | output | 32 | Translated configuration address |
| cfg_req_be | output | 4 | Byte enables |
| cfg_req_wdata | output | 32 | Downstream write data |
| cfg_rsp_valid | input | 1 | Downstream completion |
| cfg_rsp_rdata | input | 32 | Downstream read data |
| dev_intx | input | NUM_SLOTS*4 | Interrupt pins, four per slot |
| irq_out | output | 4 | Shared interrupt lines |

## Verification
The hardest case to reach from the ports is back-pressure on both sides at once. A downstream request must wait several cycles for `cfg_req_ready`, and the finished response must then wait for `host_rsp_ready`. During both waits, a new host request must stay blocked.

The bench reaches this with a downstream responder that takes a per-transaction stall count from the scoreboard queue. It pairs that with a host driver that withholds `host_rsp_ready` for a chosen number of cycles and compares the held data cycle by cycle.

The bench also covers the one-hot form with several bits set and with none set, so that the lowest-bit rule and the all-ones slot value are both observed.

// File: rtl/cax_pkg.sv
package cax_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;
  localparam int LINES  = 4;
  localparam int SLOT_LSB = 11;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } cax_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } cax_state_e;

  typedef struct packed {
    logic              write;
    logic [WORD_W-1:0] addr;
    logic [BE_W-1:0]   be;
    logic [WORD_W-1:0] wdata;
  } cax_cfg_req_t;
endpackage

// File: rtl/cax_addr_xlate.sv
module cax_addr_xlate
  import cax_pkg::*;
(
  input  logic [WORD_W-1:0] index_q,
  input  logic [2:0]        win_off,
  output logic [WORD_W-1:0] xl_addr
);
  logic [WORD_W-1:0] slot_num;
  logic [WORD_W-1:0] onehot_addr;

  // lowest set bit at or above SLOT_LSB, all ones when none
  always_comb begin
    slot_num = '1;
    for (int b = WORD_W - 1; b >= SLOT_LSB; b--) begin
      if (index_q[b]) slot_num = WORD_W'(b);
    end
  end

  always_comb begin
    onehot_addr = (slot_num << SLOT_LSB)
                | {21'd0, index_q[10:8], 8'd0}
                | {24'd0, index_q[7:3], 3'd0}
                | {29'd0, win_off};
  end

  always_comb begin
    if (index_q[WORD_W-1]) begin
      xl_addr = {index_q[WORD_W-1:2], win_off[1:0]};
    end else if (index_q[0]) begin
      xl_addr = {index_q[WORD_W-1:3], win_off};
    end else begin
      xl_addr = onehot_addr;
    end
  end
endmodule

// File: rtl/cax_be_gen.sv
module cax_be_gen
  import cax_pkg::*;
(
  input  logic [1:0]      size,
  input  logic [1:0]      lane,
  output logic [BE_W-1:0] be
);
  always_comb begin
    case (cax_size_e'(size))
      SZ_BYTE: be = BE_W'(4'b0001 << lane);
      SZ_HALF: be = lane[1] ? 4'b1100 : 4'b0011;
      default: be = 4'b1111;
    endcase
  end
endmodule

// File: rtl/cax_irq_route.sv
module cax_irq_route
  import cax_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_BASE = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SLOTS*4-1:0] dev_intx,
  output logic [LINES-1:0]       irq_out
);
  logic [LINES-1:0] line_hit;

  for (genvar k = 0; k < LINES; k++) begin : g_line
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int p = 0; p < 4; p++) begin
          if (((p + SLOT_BASE + s) % LINES) == k) acc = acc | dev_intx[s*4+p];
        end
      end
    end
    assign line_hit[k] = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= line_hit;
  end
endmodule

// File: rtl/cax_host_ctrl.sv
module cax_host_ctrl
  import cax_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic              host_req_data_win,
  input  logic [WORD_W-1:0] host_req_wdata,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [WORD_W-1:0] host_rsp_rdata,
  input  logic [WORD_W-1:0] xl_addr,
  input  logic [BE_W-1:0]   xl_be,
  output logic [WORD_W-1:0] index_q,
  output cax_cfg_req_t      cfg_req,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  input  logic              cfg_rsp_valid,
  input  logic [WORD_W-1:0] cfg_rsp_rdata
);
  cax_state_e        state;
  cax_cfg_req_t      req_q;
  logic [WORD_W-1:0] rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      index_q <= '0;
      req_q   <= '0;
      rsp_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (host_req_valid) begin
            if (!host_req_data_win) begin
              if (host_req_write) index_q <= host_req_wdata;
              rsp_q <= host_req_write ? '0 : index_q;
              state <= ST_RESP;
            end else begin
              req_q.write <= host_req_write;
              req_q.addr  <= xl_addr;
              req_q.be    <= xl_be;
              req_q.wdata <= host_req_wdata;
              state       <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: if (cfg_req_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (cfg_rsp_valid) begin
            rsp_q <= req_q.write ? '0 : cfg_rsp_rdata;
            state <= ST_RESP;
          end
        end
        ST_RESP: if (host_rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign host_req_ready = (state == ST_IDLE);
  assign cfg_req_valid  = (state == ST_ISSUE);
  assign host_rsp_valid = (state == ST_RESP);
  assign host_rsp_rdata = rsp_q;
  assign cfg_req        = req_q;
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cax_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_BASE = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_req_valid,
  output logic                   host_req_ready,
  input  logic                   host_req_write,
  input  logic [OFF_W:0]         host_req_addr,
  input  logic [1:0]             host_req_size,
  input  logic [31:0]            host_req_wdata,
  output logic                   host_rsp_valid,
  input  logic                   host_rsp_ready,
  output logic [31:0]            host_rsp_rdata,
  output logic                   cfg_req_valid,
  input  logic                   cfg_req_ready,
  output logic                   cfg_req_write,
  output logic [31:0]            cfg_req_addr,
  output logic [3:0]             cfg_req_be,
  output logic [31:0]            cfg_req_wdata,
  input  logic                   cfg_rsp_valid,
  input  logic [31:0]            cfg_rsp_rdata,
  input  logic [NUM_SLOTS*4-1:0] dev_intx,
  output logic [3:0]             irq_out
);
  logic [WORD_W-1:0] index_q;
  logic [WORD_W-1:0] xl_addr;
  logic [BE_W-1:0]   xl_be;
  cax_cfg_req_t      cfg_req;
  logic              unused_off;

  assign unused_off = ^host_req_addr[OFF_W-1:3];

  cax_addr_xlate u_xlate (
    .index_q (index_q),
    .win_off (host_req_addr[2:0]),
    .xl_addr (xl_addr)
  );

  cax_be_gen u_be (
    .size (host_req_size),
    .lane (host_req_addr[1:0]),
    .be   (xl_be)
  );

  cax_host_ctrl u_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .host_req_valid    (host_req_valid),
    .host_req_ready    (host_req_ready),
    .host_req_write    (host_req_write),
    .host_req_data_win (host_req_addr[OFF_W]),
    .host_req_wdata    (host_req_wdata),
    .host_rsp_valid    (host_rsp_valid),
    .host_rsp_ready    (host_rsp_ready),
    .host_rsp_rdata    (host_rsp_rdata),
    .xl_addr           (xl_addr),
    .xl_be             (xl_be),
    .index_q           (index_q),
    .cfg_req           (cfg_req),
    .cfg_req_valid     (cfg_req_valid),
    .cfg_req_ready     (cfg_req_ready),
    .cfg_rsp_valid     (cfg_rsp_valid),
    .cfg_rsp_rdata     (cfg_rsp_rdata)
  );

  assign cfg_req_write = cfg_req.write;
  assign cfg_req_addr  = cfg_req.addr;
  assign cfg_req_be    = cfg_req.be;
  assign cfg_req_wdata = cfg_req.wdata;

  cax_irq_route #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_BASE (SLOT_BASE)
  ) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_intx (dev_intx),
    .irq_out  (irq_out)
  );
endmodule

// File: rtl/cax_checker.sv
module cax_checker #(
  parameter int NUM_SLOTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   host_req_valid,
  input logic                   host_req_ready,
  input logic                   host_req_win,
  input logic                   host_rsp_valid,
  input logic                   host_rsp_ready,
  input logic [31:0]            host_rsp_rdata,
  input logic                   cfg_req_valid,
  input logic                   cfg_req_ready,
  input logic                   cfg_req_write,
  input logic [31:0]            cfg_req_addr,
  input logic [3:0]             cfg_req_be,
  input logic [31:0]            cfg_req_wdata,
  input logic                   cfg_rsp_valid,
  input logic [NUM_SLOTS*4-1:0] dev_intx,
  input logic [3:0]             irq_out
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_addr) && $stable(cfg_req_be) && $stable(cfg_req_wdata) && $stable(cfg_req_write)); // R7
  AST_DATA_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_valid && host_req_ready && host_req_win |=> cfg_req_valid); // R7
  AST_INDEX_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_valid && host_req_ready && !host_req_win |=> host_rsp_valid && !cfg_req_valid); // R1
  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid && !host_rsp_ready |=> host_rsp_valid && $stable(host_rsp_rdata)); // R8
  AST_ACK_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rsp_valid && !host_req_ready && !cfg_req_valid && !host_rsp_valid |=> host_rsp_valid); // R7
  AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> ($countones(cfg_req_be) == 1 || cfg_req_be == 4'b0011 || cfg_req_be == 4'b1100 || cfg_req_be == 4'b1111)); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dev_intx) == '0 |-> irq_out == 4'd0); // R9
endmodule

bind cfg_addr_xlate cax_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_req_valid (host_req_valid),
  .host_req_ready (host_req_ready),
  .host_req_win   (host_req_addr[OFF_W]),
  .host_rsp_valid (host_rsp_valid),
  .host_rsp_ready (host_rsp_ready),
  .host_rsp_rdata (host_rsp_rdata),
  .cfg_req_valid  (cfg_req_valid),
  .cfg_req_ready  (cfg_req_ready),
  .cfg_req_write  (cfg_req_write),
  .cfg_req_addr   (cfg_req_addr),
  .cfg_req_be     (cfg_req_be),
  .cfg_req_wdata  (cfg_req_wdata),
  .cfg_rsp_valid  (cfg_rsp_valid),
  .dev_intx       (dev_intx),
  .irq_out        (irq_out)
);

// File: tb/sim_cfg_addr_xlate.sv
module sim_cfg_addr_xlate;
  localparam int NS = 4;
  localparam int SB = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_write = 1'b0;
  logic [12:0] host_req_addr = '0;
  logic [1:0]  host_req_size = '0;
  logic [31:0] host_req_wdata = '0;
  logic        host_rsp_valid;
  logic        host_rsp_ready = 1'b0;
  logic [31:0] host_rsp_rdata;
  logic        cfg_req_valid;
  logic        cfg_req_ready = 1'b0;
  logic        cfg_req_write;
  logic [31:0] cfg_req_addr;
  logic [3:0]  cfg_req_be;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;
  logic [NS*4-1:0] dev_intx = '0;
  logic [3:0]  irq_out;

  always #4 clk = ~clk;

  cfg_addr_xlate #(.OFF_W(12), .NUM_SLOTS(NS), .SLOT_BASE(SB)) u0 (.*);

  typedef struct {
    bit          wr;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] rdata;
    int          stall;
    string       req;
  } item_t;

  item_t expq[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] idx_model = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_addr(logic [31:0] i, logic [2:0] o);
    logic [31:0] slot;
    if (i[31]) return {i[31:2], o[1:0]};
    if (i[0]) return {i[31:3], o};
    slot = 32'hFFFF_FFFF;
    for (int b = 11; b < 32; b++) begin
      if (i[b]) begin slot = b; break; end
    end
    return (slot << 11) | {21'd0, i[10:8], 8'd0} | {24'd0, i[7:3], 3'd0} | {29'd0, o};
  endfunction

  function automatic logic [3:0] m_be(logic [1:0] sz, logic [1:0] o);
    case (sz)
      2'd0: return 4'(4'b0001 << o);
      2'd1: return o[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // host driver: call right after a negedge
  task automatic host_xfer(input bit win, input bit wr, input logic [11:0] off,
                           input logic [1:0] sz, input logic [31:0] wd,
                           input int rstall, output logic [31:0] rd);
    logic [31:0] held;
    host_req_valid = 1'b1; host_req_write = wr; host_req_addr = {win, off};
    host_req_size = sz; host_req_wdata = wd;
    while (!host_req_ready) @(negedge clk);
    @(negedge clk);
    host_req_valid = 1'b0;
    check("R8 busy blocks host", {31'd0, host_req_ready}, 32'd0);
    while (!host_rsp_valid) @(negedge clk);
    for (int k = 0; k < rstall; k++) begin
      held = host_rsp_rdata;
      @(negedge clk);
      check("R8 response held", {31'd0, host_rsp_valid}, 32'd1);
      check("R8 response data held", host_rsp_rdata, held);
    end
    rd = host_rsp_rdata;
    host_rsp_ready = 1'b1;
    @(negedge clk);
    host_rsp_ready = 1'b0;
  endtask

  task automatic data_access(string req, bit wr, logic [11:0] off, logic [1:0] sz,
                             logic [31:0] wd, logic [31:0] devdata, int stall, int rstall);
    item_t it;
    logic [31:0] rd;
    it.wr = wr; it.addr = m_addr(idx_model, off[2:0]); it.be = m_be(sz, off[1:0]);
    it.wdata = wd; it.rdata = devdata; it.stall = stall; it.req = req;
    expq.push_back(it);
    host_xfer(1'b1, wr, off, sz, wd, rstall, rd);
    check({"R7 host data ", req}, rd, wr ? 32'd0 : devdata);
  endtask

  task automatic index_write(logic [31:0] v, logic [11:0] off, logic [1:0] sz);
    logic [31:0] rd;
    host_xfer(1'b0, 1'b1, off, sz, v, 0, rd);
    idx_model = v;
  endtask

  // downstream responder and scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (cfg_req_valid) begin
        if (expq.size() == 0) begin
          check("R1 unexpected downstream request", 32'd1, 32'd0);
          it.stall = 0; it.rdata = '0; it.req = "none";
          it.addr = cfg_req_addr; it.be = cfg_req_be; it.wr = cfg_req_write; it.wdata = cfg_req_wdata;
        end else begin
          it = expq.pop_front();
        end
        check({it.req, " addr"}, cfg_req_addr, it.addr);
        check({"R6 be ", it.req}, {28'd0, cfg_req_be}, {28'd0, it.be});
        check({"R7 write flag ", it.req}, {31'd0, cfg_req_write}, {31'd0, it.wr});
        if (it.wr) check({"R7 wdata ", it.req}, cfg_req_wdata, it.wdata);
        for (int k = 0; k < it.stall; k++) @(negedge clk);
        if (it.stall > 0) begin
          check({"R7 addr held ", it.req}, cfg_req_addr, it.addr);
          check({"R7 valid held ", it.req}, {31'd0, cfg_req_valid}, 32'd1);
        end
        cfg_req_ready = 1'b1;
        @(negedge clk);
        cfg_req_ready = 1'b0;
        cfg_rsp_valid = 1'b1;
        cfg_rsp_rdata = it.rdata;
        @(negedge clk);
        cfg_rsp_valid = 1'b0;
        cfg_rsp_rdata = '0;
      end
    end
  end

  task automatic irq_check(logic [NS*4-1:0] pat);
    logic [3:0] exp;
    exp = '0;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < 4; p++)
        if (pat[s*4+p]) exp[(p + SB + s) % 4] = 1'b1;
    dev_intx = pat;
    @(negedge clk);
    check("R9 irq routing", {28'd0, irq_out}, {28'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    check("R10 irq after reset", {28'd0, irq_out}, 32'd0);
    check("R10 no request", {31'd0, cfg_req_valid}, 32'd0);
    check("R10 no response", {31'd0, host_rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle ready", {31'd0, host_req_ready}, 32'd1);
    check("R10 irq low", {28'd0, irq_out}, 32'd0);

    host_xfer(1'b0, 1'b0, 12'h000, 2'd2, '0, 0, rd);
    check("R1 index reset value", rd, 32'd0);
    index_write(32'h8001_2344, 12'h005, 2'd0);
    host_xfer(1'b0, 1'b0, 12'h7F0, 2'd0, '0, 2, rd);
    check("R1 full index readback", rd, 32'h8001_2344);

    data_access("R2 pass byte", 1'b0, 12'h003, 2'd0, '0, 32'hA5A5_0001, 0, 0);
    data_access("R2 pass half", 1'b1, 12'h006, 2'd1, 32'h1234_0000, '0, 2, 0);

    index_write(32'h0000_0B05, 12'h000, 2'd2);
    data_access("R3 type1 byte", 1'b1, 12'h007, 2'd0, 32'hEE00_0000, '0, 0, 1);
    data_access("R3 type1 word", 1'b0, 12'h004, 2'd3, '0, 32'hCAFE_F00D, 3, 2);

    index_write(32'h0000_0DA8, 12'h000, 2'd2);
    data_access("R4 slot eleven", 1'b0, 12'h002, 2'd2, '0, 32'h0BAD_BEEF, 1, 0);
    index_write(32'h4000_2010, 12'h000, 2'd2);
    data_access("R4 lowest bit wins", 1'b1, 12'h004, 2'd1, 32'h0000_5678, '0, 0, 0);
    index_write(32'h4000_0300, 12'h000, 2'd2);
    data_access("R4 slot thirty", 1'b0, 12'h001, 2'd0, '0, 32'h1111_2222, 4, 3);

    index_write(32'h0000_0720, 12'h000, 2'd2);
    data_access("R5 empty slot field", 1'b0, 12'h001, 2'd0, '0, 32'h3333_4444, 0, 0);
    data_access("R6 half upper", 1'b0, 12'h002, 2'd1, '0, 32'h5555_6666, 0, 0);

    for (int b = 0; b < NS * 4; b++) irq_check(16'(1) << b);
    irq_check(16'h8421);
    irq_check(16'h00F0);
    irq_check(16'h0000);

    repeat (4) @(negedge clk);
    check("R1 scoreboard drained", expq.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule